// File: doc/BRIEF.md
# Instruction Prefix Decode Stage

This block is the first decode step for a variable-length instruction stream. It receives a window of up to fifteen instruction bytes, walks the leading prefix bytes and reports what they select: operand-size and address-size overrides, bus lock, the segment override, the repeat kind, the REX register-extension bits, and whether the byte after the prefixes starts a vector-encoded, mask-encoded or two-byte-escape opcode. It also reports the byte offset where the opcode begins, so that the next stage can find it without rescanning.

Prefixes fall into two cost classes. REX bytes and the vector, mask and escape lead bytes cost nothing: a window made only of those returns its result on the cycle after it is accepted, and a new window may be taken every cycle. Any legacy prefix (size overrides, lock, segment, repeat) makes the stage stall. Input ready drops for a fixed two cycles, and the result comes out two cycles later than on the fast path. The charge is made once for each instruction, however many legacy prefixes the instruction carries.

The window is byte-packed: byte i sits at `in_bytes[8*i+7:8*i]`. Results are registered. `out_valid` pulses for one cycle per accepted window, and the result fields hold their value until the next result.

Top module: `pfx_decode_stage`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `stall` is 0.
- R2: A window whose prefix run holds no legacy prefix is accepted with no stall, and its result shows `out_valid` on the cycle after acceptance. The opcode byte 0x62 sets `out_vec`, 0xC4 or 0xC5 sets `out_mask`, and 0x0F sets `out_esc`. Any other opcode byte leaves all three at 0.
- R3: The legacy prefixes are 0x66, 0x67, 0xF0, 0xF2, 0xF3, 0x26, 0x2E, 0x36, 0x3E, 0x64 and 0x65. If any of them appears in the prefix run, `in_ready` is 0 and `stall` is 1 for exactly two cycles after acceptance. `out_valid` rises on the cycle after that, with `stall` back at 0.
- R4: A window with several legacy prefixes incurs the same two-cycle penalty as a window with one.
- R5: The prefix run is the longest leading run of legacy and REX (0x40 to 0x4F) bytes. `out_offset` is the index of the first byte outside that run, or 15 if all fifteen bytes are prefixes. With no opcode byte, `out_vec`, `out_mask`, `out_esc` and `out_rex_valid` are 0.
- R6: `out_opsz` is set by 0x66, `out_adsz` by 0x67 and `out_lock` by 0xF0, each when that byte appears anywhere in the prefix run.
- R7: `out_seg` encodes the last segment prefix in the run: 0x26→1, 0x2E→2, 0x36→3, 0x3E→4, 0x64→5, 0x65→6. It is 0 when the run has no segment prefix.
- R8: `out_rep` encodes the last repeat prefix in the run: 0xF2→1, 0xF3→2. It is 0 when the run has no repeat prefix.
- R9: A REX byte counts only when it sits at index `out_offset-1` and an opcode byte exists. In that case `out_rex_valid` is 1 and `out_rex_wrxb` equals that byte's low nibble (bit 3 W, bit 2 R, bit 1 X, bit 0 B). Otherwise both are 0.
- R10: While `in_ready` is 0, `in_valid` and `in_bytes` are ignored. The pending result is the window that was accepted, and no extra result is produced for a window offered during the stall.
- R11: With `in_valid` held high and fast windows only, one result comes out every cycle, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window offered |
| in_bytes | input | 120 | Instruction bytes, byte i at bits 8i+7:8i |
| in_ready | output | 1 | Stage can accept a window |
| out_valid | output | 1 | One-cycle pulse: result fields are new |
| out_opsz | output | 1 | Operand-size override seen |
| out_adsz | output | 1 | Address-size override seen |
| out_lock | output | 1 | Lock prefix seen |
| out_seg | output | 3 | Segment override code |
| out_rep | output | 2 | Repeat kind code |
| out_rex_valid | output | 1 | REX byte applies to the opcode |
| out_rex_wrxb | output | 4 | REX W, R, X, B bits |
| out_vec | output | 1 | Opcode starts with the vector lead byte |
| out_mask | output | 1 | Opcode starts with a mask lead byte |
| out_esc | output | 1 | Opcode starts with the escape byte |
| out_offset | output | 4 | Index of first non-prefix byte |
| stall | output | 1 | Legacy penalty in progress |

## Verification
Most faults in the penalty counter show up as a wrong stall length. The `in_ready` low window becomes one or three cycles instead of two, or `out_valid` arrives early, late, twice or never, and this is visible within three cycles of acceptance. A fault in the scan shows up in the result fields on the first `out_valid` pulse: an offset that is off by one, a REX that is taken from the wrong position, or a segment or repeat code that keeps the first prefix of its group instead of the last. A latched pending result that is overwritten during a stall would show the later window's fields in place of the accepted one.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    // segment override codes
    localparam logic [2:0] SEG_NONE = 3'd0;
    localparam logic [2:0] SEG_ES   = 3'd1;
    localparam logic [2:0] SEG_CS   = 3'd2;
    localparam logic [2:0] SEG_SS   = 3'd3;
    localparam logic [2:0] SEG_DS   = 3'd4;
    localparam logic [2:0] SEG_FS   = 3'd5;
    localparam logic [2:0] SEG_GS   = 3'd6;

    // repeat kind codes
    localparam logic [1:0] REP_NONE = 2'd0;
    localparam logic [1:0] REP_NE   = 2'd1;
    localparam logic [1:0] REP_E    = 2'd2;

    // opcode lead bytes that need no extra cycles
    localparam logic [7:0] LEAD_VEC  = 8'h62;
    localparam logic [7:0] LEAD_MSK0 = 8'hC4;
    localparam logic [7:0] LEAD_MSK1 = 8'hC5;
    localparam logic [7:0] LEAD_ESC  = 8'h0F;

    typedef struct packed {
        logic       legacy;
        logic       rex;
        logic       opsz;
        logic       adsz;
        logic       lock;
        logic [2:0] seg;
        logic [1:0] rep;
    } byte_cls_t;

    typedef struct packed {
        logic       opsz;
        logic       adsz;
        logic       lock;
        logic [2:0] seg;
        logic [1:0] rep;
        logic       rex_v;
        logic [3:0] rex_wrxb;
        logic       vec;
        logic       mask;
        logic       esc;
    } pfx_attr_t;

endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class
    import pfx_pkg::*;
(
    input  logic [7:0] b,
    output byte_cls_t  cls
);
    always_comb begin
        cls = '0;
        unique case (b)
            8'h66: begin cls.legacy = 1'b1; cls.opsz = 1'b1; end
            8'h67: begin cls.legacy = 1'b1; cls.adsz = 1'b1; end
            8'hF0: begin cls.legacy = 1'b1; cls.lock = 1'b1; end
            8'hF2: begin cls.legacy = 1'b1; cls.rep = REP_NE; end
            8'hF3: begin cls.legacy = 1'b1; cls.rep = REP_E; end
            8'h26: begin cls.legacy = 1'b1; cls.seg = SEG_ES; end
            8'h2E: begin cls.legacy = 1'b1; cls.seg = SEG_CS; end
            8'h36: begin cls.legacy = 1'b1; cls.seg = SEG_SS; end
            8'h3E: begin cls.legacy = 1'b1; cls.seg = SEG_DS; end
            8'h64: begin cls.legacy = 1'b1; cls.seg = SEG_FS; end
            8'h65: begin cls.legacy = 1'b1; cls.seg = SEG_GS; end
            default: cls.rex = (b[7:4] == 4'h4);
        endcase
    end
endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
    import pfx_pkg::*;
#(
    parameter int WIN_BYTES = 15,
    parameter int OFF_W     = $clog2(WIN_BYTES + 1)
) (
    input  logic [8*WIN_BYTES-1:0] win,
    output pfx_attr_t              attr,
    output logic [OFF_W-1:0]       offset,
    output logic                   legacy
);
    logic [7:0] byt [WIN_BYTES];
    byte_cls_t  cls [WIN_BYTES];

    genvar g;
    generate
        for (g = 0; g < WIN_BYTES; g++) begin : g_byte
            assign byt[g] = win[8*g +: 8];
            pfx_byte_class u_cls (
                .b  (byt[g]),
                .cls(cls[g])
            );
        end
    endgenerate

    // end of the prefix run
    always_comb begin
        logic hit;
        hit    = 1'b0;
        offset = OFF_W'(WIN_BYTES);
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (!hit && !(cls[i].legacy || cls[i].rex)) begin
                offset = OFF_W'(i);
                hit    = 1'b1;
            end
        end
    end

    // accumulate attributes over the run, later bytes overriding
    always_comb begin
        attr   = '0;
        legacy = 1'b0;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (OFF_W'(i) < offset) begin
                legacy    = legacy | cls[i].legacy;
                attr.opsz = attr.opsz | cls[i].opsz;
                attr.adsz = attr.adsz | cls[i].adsz;
                attr.lock = attr.lock | cls[i].lock;
                if (cls[i].seg != SEG_NONE) attr.seg = cls[i].seg;
                if (cls[i].rep != REP_NONE) attr.rep = cls[i].rep;
            end
        end
        for (int i = 1; i < WIN_BYTES; i++) begin
            if (OFF_W'(i) == offset && cls[i-1].rex) begin
                attr.rex_v    = 1'b1;
                attr.rex_wrxb = byt[i-1][3:0];
            end
        end
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (OFF_W'(i) == offset) begin
                attr.vec  = (byt[i] == LEAD_VEC);
                attr.mask = (byt[i] == LEAD_MSK0) || (byt[i] == LEAD_MSK1);
                attr.esc  = (byt[i] == LEAD_ESC);
            end
        end
    end
endmodule

// File: rtl/pfx_decode_stage.sv
module pfx_decode_stage
    import pfx_pkg::*;
#(
    parameter int WIN_BYTES = 15,
    parameter int PEN_CYC   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [8*WIN_BYTES-1:0] in_bytes,
    output logic                   in_ready,
    output logic                   out_valid,
    output logic                   out_opsz,
    output logic                   out_adsz,
    output logic                   out_lock,
    output logic [2:0]             out_seg,
    output logic [1:0]             out_rep,
    output logic                   out_rex_valid,
    output logic [3:0]             out_rex_wrxb,
    output logic                   out_vec,
    output logic                   out_mask,
    output logic                   out_esc,
    output logic [$clog2(WIN_BYTES+1)-1:0] out_offset,
    output logic                   stall
);
    localparam int OFF_W = $clog2(WIN_BYTES + 1);
    localparam int CNT_W = $clog2(PEN_CYC + 1);
    localparam logic [CNT_W-1:0] PEN_LOAD = CNT_W'(PEN_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        pfx_attr_t        pend_a;
        logic [OFF_W-1:0] pend_off;
        pfx_attr_t        out_a;
        logic [OFF_W-1:0] out_off;
        logic             out_v;
    } st_t;

    st_t s_d, s_q;

    pfx_attr_t        scan_a;
    logic [OFF_W-1:0] scan_off;
    logic             scan_leg;

    pfx_scan #(
        .WIN_BYTES(WIN_BYTES),
        .OFF_W    (OFF_W)
    ) u_scan (
        .win   (in_bytes),
        .attr  (scan_a),
        .offset(scan_off),
        .legacy(scan_leg)
    );

    always_comb begin
        s_d       = s_q;
        s_d.out_v = 1'b0;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.out_a   = s_q.pend_a;
                s_d.out_off = s_q.pend_off;
                s_d.out_v   = 1'b1;
            end
        end else if (in_valid) begin
            if (scan_leg) begin
                s_d.cnt      = PEN_LOAD;
                s_d.pend_a   = scan_a;
                s_d.pend_off = scan_off;
            end else begin
                s_d.out_a   = scan_a;
                s_d.out_off = scan_off;
                s_d.out_v   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready      = (s_q.cnt == '0);
    assign stall         = (s_q.cnt != '0);
    assign out_valid     = s_q.out_v;
    assign out_opsz      = s_q.out_a.opsz;
    assign out_adsz      = s_q.out_a.adsz;
    assign out_lock      = s_q.out_a.lock;
    assign out_seg       = s_q.out_a.seg;
    assign out_rep       = s_q.out_a.rep;
    assign out_rex_valid = s_q.out_a.rex_v;
    assign out_rex_wrxb  = s_q.out_a.rex_wrxb;
    assign out_vec       = s_q.out_a.vec;
    assign out_mask      = s_q.out_a.mask;
    assign out_esc       = s_q.out_a.esc;
    assign out_offset    = s_q.out_off;

    // R3
    stall_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !out_valid);
    // R3
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> out_valid);
    // R11
    accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid || stall));
    // R2
    lead_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_vec, out_mask, out_esc}));
    // R9
    rex_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rex_valid) |-> (out_offset != '0));
    // R5
    no_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_offset == OFF_W'(WIN_BYTES))
            |-> !(out_vec || out_mask || out_esc || out_rex_valid));
endmodule

// File: tb/pfx_decode_stage_bench.sv
module pfx_decode_stage_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [119:0] in_bytes = '0;
    logic         in_ready, out_valid, out_opsz, out_adsz, out_lock;
    logic [2:0]   out_seg;
    logic [1:0]   out_rep;
    logic         out_rex_valid;
    logic [3:0]   out_rex_wrxb;
    logic         out_vec, out_mask, out_esc;
    logic [3:0]   out_offset;
    logic         stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] win [15];

    always #(CLK_PERIOD/2) clk = ~clk;

    pfx_decode_stage u_pfx_decode_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
        .in_ready(in_ready), .out_valid(out_valid), .out_opsz(out_opsz),
        .out_adsz(out_adsz), .out_lock(out_lock), .out_seg(out_seg),
        .out_rep(out_rep), .out_rex_valid(out_rex_valid),
        .out_rex_wrxb(out_rex_wrxb), .out_vec(out_vec), .out_mask(out_mask),
        .out_esc(out_esc), .out_offset(out_offset), .stall(stall)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_win();
        for (int i = 0; i < 15; i++) win[i] = 8'h90;
    endtask

    function automatic logic [119:0] pack_win();
        logic [119:0] v;
        for (int i = 0; i < 15; i++) v[8*i +: 8] = win[i];
        return v;
    endfunction

    // offer win once; checks handshake timing, leaves the result on the ports
    task automatic send(input string req, input bit legacy);
        @(negedge clk);
        chk(req, "ready before", int'(in_ready), 1);
        in_bytes = pack_win();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (legacy) begin
            for (int c = 0; c < 2; c++) begin
                chk(req, "stall", int'(stall), 1);
                chk(req, "ready low", int'(in_ready), 0);
                chk(req, "no early result", int'(out_valid), 0);
                @(negedge clk);
            end
        end
        chk(req, "out_valid", int'(out_valid), 1);
        chk(req, "stall clear", int'(stall), 0);
    endtask

    task automatic expect_res(input string req, input int opsz, input int adsz,
                              input int lock, input int seg, input int rep,
                              input int rexv, input int wrxb, input int vec,
                              input int msk, input int esc, input int off);
        chk(req, "opsz", int'(out_opsz), opsz);
        chk(req, "adsz", int'(out_adsz), adsz);
        chk(req, "lock", int'(out_lock), lock);
        chk(req, "seg", int'(out_seg), seg);
        chk(req, "rep", int'(out_rep), rep);
        chk(req, "rex_valid", int'(out_rex_valid), rexv);
        chk(req, "rex_wrxb", int'(out_rex_wrxb), wrxb);
        chk(req, "vec", int'(out_vec), vec);
        chk(req, "mask", int'(out_mask), msk);
        chk(req, "esc", int'(out_esc), esc);
        chk(req, "offset", int'(out_offset), off);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "stall", int'(stall), 0);
    endtask

    task automatic t_fast();
        clear_win(); win[0] = 8'h62;
        send("R2", 1'b0);
        expect_res("R2", 0,0,0,0,0, 0,0, 1,0,0, 0);
        clear_win(); win[0] = 8'h48; win[1] = 8'hC5;
        send("R2", 1'b0);
        expect_res("R9", 0,0,0,0,0, 1,8, 0,1,0, 1);
        clear_win(); win[0] = 8'h41; win[1] = 8'h0F;
        send("R2", 1'b0);
        expect_res("R9", 0,0,0,0,0, 1,1, 0,0,1, 1);
        clear_win(); win[0] = 8'hC4;
        send("R2", 1'b0);
        expect_res("R2", 0,0,0,0,0, 0,0, 0,1,0, 0);
    endtask

    task automatic t_legacy_one();
        clear_win(); win[0] = 8'h66; win[1] = 8'h0F;
        send("R3", 1'b1);
        expect_res("R6", 1,0,0,0,0, 0,0, 0,0,1, 1);
    endtask

    task automatic t_legacy_many();
        clear_win();
        win[0] = 8'hF0; win[1] = 8'h67; win[2] = 8'h2E; win[3] = 8'h65;
        win[4] = 8'hF2; win[5] = 8'hF3; win[6] = 8'h4C; win[7] = 8'h8B;
        send("R4", 1'b1);
        expect_res("R7_R8", 0,1,1,6,2, 1,12, 0,0,0, 7);
    endtask

    task automatic t_rex_not_last();
        clear_win(); win[0] = 8'h48; win[1] = 8'h66; win[2] = 8'h89;
        send("R3", 1'b1);
        expect_res("R9", 1,0,0,0,0, 0,0, 0,0,0, 2);
    endtask

    task automatic t_all_prefix();
        clear_win();
        for (int i = 0; i < 14; i++) win[i] = 8'h3E;
        win[14] = 8'h4F;
        send("R5", 1'b1);
        expect_res("R5", 0,0,0,4,0, 0,0, 0,0,0, 15);
    endtask

    task automatic t_seg_codes();
        logic [7:0] codes [6];
        codes = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65};
        for (int k = 0; k < 6; k++) begin
            clear_win(); win[0] = 8'hF3; win[1] = codes[k]; win[2] = 8'hF2;
            send("R7", 1'b1);
            chk("R7", "seg code", int'(out_seg), k + 1);
            chk("R8", "last rep", int'(out_rep), 1);
        end
        clear_win(); win[0] = 8'h26; win[1] = 8'h64; win[2] = 8'h3E;
        send("R7", 1'b1);
        chk("R7", "last seg wins", int'(out_seg), 4);
    endtask

    task automatic t_ignore_in_stall();
        clear_win(); win[0] = 8'h67; win[1] = 8'h90;
        @(negedge clk);
        in_bytes = pack_win(); in_valid = 1'b1;
        @(negedge clk);
        clear_win(); win[0] = 8'h62;
        in_bytes = pack_win();
        chk("R10", "ready low", int'(in_ready), 0);
        @(negedge clk);
        chk("R10", "ready low 2", int'(in_ready), 0);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10", "out_valid", int'(out_valid), 1);
        expect_res("R10", 0,1,0,0,0, 0,0, 0,0,0, 1);
        @(negedge clk);
        chk("R10", "no extra result", int'(out_valid), 0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        clear_win(); win[0] = 8'h62; in_bytes = pack_win(); in_valid = 1'b1;
        @(negedge clk);
        chk("R11", "first valid", int'(out_valid), 1);
        chk("R11", "first vec", int'(out_vec), 1);
        clear_win(); win[0] = 8'h0F; in_bytes = pack_win();
        @(negedge clk);
        chk("R11", "second valid", int'(out_valid), 1);
        chk("R11", "second esc", int'(out_esc), 1);
        clear_win(); win[0] = 8'h43; win[1] = 8'hC4; in_bytes = pack_win();
        @(negedge clk);
        chk("R11", "third valid", int'(out_valid), 1);
        chk("R11", "third mask", int'(out_mask), 1);
        chk("R11", "third wrxb", int'(out_rex_wrxb), 3);
        chk("R11", "third stall", int'(stall), 0);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11", "idle", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fast();
        t_legacy_one();
        t_legacy_many();
        t_rex_not_last();
        t_all_prefix();
        t_seg_codes();
        t_ignore_in_stall();
        t_back_to_back();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule